// File: doc/BRIEF.md
# Security Backdoor Unlock Guard

This block holds the security state of a nonvolatile memory array and offers a way to unlock it with a secret key. At reset it takes a two-bit security code and a key-enable bit from option inputs. Only the code `2'b10` means unsecured. The other three codes all mean secured.

An unlock attempt is a session. A session is open while the key-enable option bit and the software key-access input are both high. During a session, array writes do not go to the command path. Each one is checked against the next of four stored 16-bit key words instead. The words must arrive as aligned word writes at the key window, one after another from the lowest offset upwards. If a write arrives out of turn, has the wrong value, is a byte write, is a fifth write, or comes from the debug path in special single-chip mode, the session is marked failed. It stays failed until key access drops and rises again.

The verdict is taken on the cycle the session closes. If all four words matched, the security code becomes unsecured. The stored keys and the option byte are not changed, so the next reset restores the code from the option input. While a session is open, array reads return a fixed invalid word.

Top module: `keyunlock_guard`

## Requirements
- R1: During reset (`rst_n` low, synchronous) the security code is loaded from `opt_sec_i` and the key-enable bit is loaded from `opt_keyen_i`. The loaded key-enable bit does not change until the next reset.
- R2: `unsecured_o` is 1 exactly when `sec_o` is `2'b10`. Codes `2'b00`, `2'b01` and `2'b11` give `unsecured_o` = 0.
- R3: A session is open while the loaded key-enable bit and `key_acc_i` are both 1. During a session `cmd_wr_o` stays 0 for every write. Outside a session, `cmd_wr_o` equals `wr_en_i` in the same cycle.
- R4: During a session `rd_data_o` is `16'h0000`. Outside a session `rd_data_o` equals `rd_data_i` in the same cycle.
- R5: The key words `key_words_i[16*k +: 16]` (k = 0..3) must be written as word writes (`wr_word_i`=1) to `16'hFF00 + 2*k`, in order k = 0,1,2,3. When `key_acc_i` then drops, `sec_o` reads `2'b10` from the cycle after the first clock edge at which `key_acc_i` is low. The security code changes at no other time.
- R6: If any key word has the wrong value, the code stays as loaded when the session closes.
- R7: A write to an offset other than the expected next one, including any address outside the window or a write out of order, fails the session.
- R8: A fifth write after four matching words fails the session.
- R9: A byte write (`wr_word_i`=0) during a session fails it.
- R10: While `special_mode_i` is 1, a write flagged by `wr_dbg_i`=1 fails the session. Debug-path writes outside special mode, and normal writes in special mode, are compared as usual.
- R11: A failure lasts only until the session closes. A new session that starts afterwards can unlock.
- R12: An unlock is lost at the next reset, which reloads the code from `opt_sec_i`.
- R13: With the key-enable bit loaded as 0, `key_acc_i` opens no session: writes are forwarded, reads are not masked, and the code never changes.
- R14: A write in the same cycle that `key_acc_i` is already low goes to the command path and does not count as a key word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the option inputs |
| opt_sec_i | input | 2 | Security code from the option byte |
| opt_keyen_i | input | 1 | Key-enable option bit |
| key_acc_i | input | 1 | Software key-access control |
| special_mode_i | input | 1 | Device is in special single-chip mode |
| wr_en_i | input | 1 | Array write strobe |
| wr_addr_i | input | 16 | Array write byte address |
| wr_word_i | input | 1 | 1 = aligned word write, 0 = byte write |
| wr_data_i | input | 16 | Array write data |
| wr_dbg_i | input | 1 | Write originates from the debug path |
| key_words_i | input | 64 | Four stored key words, word k at bits 16k+15..16k |
| rd_data_i | input | 16 | Raw array read data |
| rd_data_o | output | 16 | Read data after masking |
| cmd_wr_o | output | 1 | Write forwarded to the command path |
| sec_o | output | 2 | Current security code |
| unsecured_o | output | 1 | Device is unsecured |

## Verification
Two things can meet in one cycle: the session closing and an array write. The bench holds three correct key words, then lowers `key_acc_i` and presents the fourth word in the same cycle. The verdict is judged on two outputs. `cmd_wr_o` must be high for that write, and `sec_o` must stay secured afterwards, because only three words were counted. The normal case, where the last word comes one cycle before the drop, unlocks. The two cases differ by a single cycle of timing.

// File: rtl/kug_pkg.sv
package kug_pkg;

    localparam logic [1:0] SEC_OPEN = 2'b10;

    typedef struct packed {
        logic [1:0] sec;
        logic       keyen;
    } sec_state_t;

endpackage

// File: rtl/kug_seq_tracker.sv
module kug_seq_tracker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned KEY_WORDS = 4,
    parameter logic [15:0] KEY_BASE  = 16'hFF00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic                        wr_word_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        dbg_block_i,
    input  logic [KEY_WORDS*DATA_W-1:0] keys_i,
    output logic                        close_o,
    output logic                        pass_o
);
    localparam int unsigned CNT_W = $clog2(KEY_WORDS + 1);
    localparam int unsigned IDX_W = $clog2(KEY_WORDS);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(KEY_WORDS);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(KEY_BASE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fail;
        logic             open;
    } seq_t;

    seq_t state_d, state_q;

    logic [DATA_W-1:0] key_arr [KEY_WORDS];

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        assign key_arr[g] = keys_i[g*DATA_W +: DATA_W];
    end

    logic [DATA_W-1:0] cur_key;
    logic [ADDR_W-1:0] exp_addr;
    logic              room_left;
    logic              good_wr;

    always_comb begin
        room_left = (state_q.cnt < CNT_MAX);
        cur_key   = room_left ? key_arr[state_q.cnt[IDX_W-1:0]] : '0;
        exp_addr  = BASE_A + {{(ADDR_W-CNT_W-1){1'b0}}, state_q.cnt, 1'b0};
        good_wr   = room_left && wr_word_i && !dbg_block_i
                    && (wr_addr_i == exp_addr) && (wr_data_i == cur_key);

        state_d      = state_q;
        state_d.open = active_i;
        if (!active_i) begin
            state_d.cnt  = '0;
            state_d.fail = 1'b0;
        end else if (wr_en_i) begin
            if (good_wr && !state_q.fail) begin
                state_d.cnt = state_q.cnt + 1'b1;
            end else begin
                state_d.fail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign close_o = state_q.open && !active_i;
    assign pass_o  = (state_q.cnt == CNT_MAX) && !state_q.fail;

endmodule

// File: rtl/kug_sec_reg.sv
module kug_sec_reg
    import kug_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] opt_sec_i,
    input  logic       opt_keyen_i,
    input  logic       unlock_i,
    output logic [1:0] sec_o,
    output logic       keyen_o,
    output logic       unsecured_o
);
    sec_state_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (unlock_i) begin
            sec_d.sec = SEC_OPEN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q.sec   <= opt_sec_i;
            sec_q.keyen <= opt_keyen_i;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign sec_o       = sec_q.sec;
    assign keyen_o     = sec_q.keyen;
    assign unsecured_o = (sec_q.sec == SEC_OPEN);

endmodule

// File: rtl/kug_read_mask.sv
module kug_read_mask #(
    parameter int unsigned       DATA_W     = 16,
    parameter logic [DATA_W-1:0] INVALID_RD = '0
) (
    input  logic              active_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    always_comb begin
        rd_data_o = rd_data_i;
        if (active_i) begin
            rd_data_o = INVALID_RD;
        end
    end
endmodule

// File: rtl/keyunlock_guard.sv
module keyunlock_guard #(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 16,
    parameter int unsigned       KEY_WORDS  = 4,
    parameter logic [15:0]       KEY_BASE   = 16'hFF00,
    parameter logic [DATA_W-1:0] INVALID_RD = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  opt_sec_i,
    input  logic                        opt_keyen_i,
    input  logic                        key_acc_i,
    input  logic                        special_mode_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic                        wr_word_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        wr_dbg_i,
    input  logic [KEY_WORDS*DATA_W-1:0] key_words_i,
    input  logic [DATA_W-1:0]           rd_data_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic                        cmd_wr_o,
    output logic [1:0]                  sec_o,
    output logic                        unsecured_o
);
    logic keyen_q;
    logic session;
    logic dbg_block;
    logic close;
    logic pass;

    assign session   = keyen_q && key_acc_i;
    assign dbg_block = special_mode_i && wr_dbg_i;
    assign cmd_wr_o  = wr_en_i && !session;

    kug_seq_tracker #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_WORDS(KEY_WORDS),
        .KEY_BASE (KEY_BASE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (session),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_word_i  (wr_word_i),
        .wr_data_i  (wr_data_i),
        .dbg_block_i(dbg_block),
        .keys_i     (key_words_i),
        .close_o    (close),
        .pass_o     (pass)
    );

    kug_sec_reg u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .opt_sec_i  (opt_sec_i),
        .opt_keyen_i(opt_keyen_i),
        .unlock_i   (close && pass),
        .sec_o      (sec_o),
        .keyen_o    (keyen_q),
        .unsecured_o(unsecured_o)
    );

    kug_read_mask #(
        .DATA_W    (DATA_W),
        .INVALID_RD(INVALID_RD)
    ) u_rd (
        .active_i (session),
        .rd_data_i(rd_data_i),
        .rd_data_o(rd_data_o)
    );

endmodule

// File: rtl/kug_guard_chk.sv
module kug_guard_chk #(
    parameter int unsigned       DATA_W     = 16,
    parameter logic [DATA_W-1:0] INVALID_RD = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_acc_i,
    input logic              wr_en_i,
    input logic              keyen_q,
    input logic              cmd_wr_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [1:0]        sec_o
);
    AST_SEC_ONLY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_o) |-> sec_o == 2'b10); // R5

    AST_SEC_CHANGE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_o) |-> (!$past(key_acc_i) && $past(key_acc_i, 2))); // R5

    AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |-> !(keyen_q && key_acc_i)); // R3

    AST_CMD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !key_acc_i) |-> cmd_wr_o); // R14

    AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (keyen_q && key_acc_i) |-> rd_data_o == INVALID_RD); // R4

    AST_KEYEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(keyen_q)); // R1

    AST_NO_KEYEN_NO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !keyen_q |=> $stable(sec_o)); // R13
endmodule

bind keyunlock_guard kug_guard_chk #(
    .DATA_W    (DATA_W),
    .INVALID_RD(INVALID_RD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_acc_i(key_acc_i),
    .wr_en_i  (wr_en_i),
    .keyen_q  (keyen_q),
    .cmd_wr_o (cmd_wr_o),
    .rd_data_o(rd_data_o),
    .sec_o    (sec_o)
);

// File: tb/keyunlock_guard_test.sv
`timescale 1ns/1ps
module keyunlock_guard_test;
    localparam logic [15:0] KB = 16'hFF00;
    localparam logic [15:0] K0 = 16'h1234;
    localparam logic [15:0] K1 = 16'hA5C3;
    localparam logic [15:0] K2 = 16'h0F0F;
    localparam logic [15:0] K3 = 16'hBEEF;
    localparam int K_SEC = 0;
    localparam int K_UNS = 1;
    localparam int K_CMD = 2;
    localparam int K_RD  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  opt_sec = 2'b00;
    logic        opt_keyen = 1'b1;
    logic        key_acc = 1'b0;
    logic        special = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        wr_word = 1'b1;
    logic [15:0] wr_data = '0;
    logic        wr_dbg = 1'b0;
    logic [63:0] keys = {K3, K2, K1, K0};
    logic [15:0] rd_in = '0;
    logic [15:0] rd_out;
    logic        cmd_wr;
    logic [1:0]  sec;
    logic        unsec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    keyunlock_guard uut (
        .clk(clk), .rst_n(rst_n), .opt_sec_i(opt_sec), .opt_keyen_i(opt_keyen),
        .key_acc_i(key_acc), .special_mode_i(special), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_word_i(wr_word), .wr_data_i(wr_data),
        .wr_dbg_i(wr_dbg), .key_words_i(keys), .rd_data_i(rd_in),
        .rd_data_o(rd_out), .cmd_wr_o(cmd_wr), .sec_o(sec), .unsecured_o(unsec)
    );

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t it;
                logic [15:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_SEC:   act = {14'b0, sec};
                    K_UNS:   act = {15'b0, unsec};
                    K_CMD:   act = {15'b0, cmd_wr};
                    default: act = rd_out;
                endcase
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s (kind %0d): actual %h expected %h", it.req, it.kind, act, it.val);
                end
            end
        end
    end

    task automatic push(input string r, input int k, input logic [15:0] v);
        exp_t it;
        it.req = r; it.kind = k; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic do_reset(input logic [1:0] s, input logic ken);
        @(negedge clk);
        rst_n = 1'b0; opt_sec = s; opt_keyen = ken; key_acc = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic word,
                      input logic dbg, input logic exp_cmd, input string r);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_word = word; wr_dbg = dbg;
        push(r, K_CMD, {15'b0, exp_cmd});
        @(negedge clk);
        wr_en = 1'b0; wr_word = 1'b1; wr_dbg = 1'b0;
    endtask

    task automatic acc(input logic v);
        @(negedge clk);
        key_acc = v;
    endtask

    task automatic chk_sec(input logic [1:0] e, input string r);
        @(negedge clk);
        push(r, K_SEC, {14'b0, e});
        push(r, K_UNS, {15'b0, (e == 2'b10)});
    endtask

    task automatic chk_rd(input logic [15:0] d, input logic [15:0] e, input string r);
        @(negedge clk);
        rd_in = d;
        push(r, K_RD, e);
    endtask

    task automatic good_keys(input string r);
        wr(KB,     K0, 1'b1, 1'b0, 1'b0, r);
        wr(KB + 2, K1, 1'b1, 1'b0, 1'b0, r);
        wr(KB + 4, K2, 1'b1, 1'b0, 1'b0, r);
        wr(KB + 6, K3, 1'b1, 1'b0, 1'b0, r);
    endtask

    initial begin
        do_reset(2'b00, 1'b1);
        chk_sec(2'b00, "R1 reset load");

        // R3 / R4 forwarding and masking
        wr(16'h8000, 16'h5555, 1'b1, 1'b0, 1'b1, "R3 forward outside session");
        chk_rd(16'hCAFE, 16'hCAFE, "R4 read passthrough");
        acc(1'b1);
        chk_rd(16'hCAFE, 16'h0000, "R4 read masked");
        acc(1'b0);

        // R5 full unlock
        acc(1'b1);
        good_keys("R3 no forward in session");
        acc(1'b0);
        chk_sec(2'b10, "R5 unlock");

        // R12 reset relocks
        do_reset(2'b00, 1'b1);
        chk_sec(2'b00, "R12 reload after unlock");

        // R6 mismatch
        acc(1'b1);
        wr(KB,     K0, 1'b1, 1'b0, 1'b0, "R6");
        wr(KB + 2, K1, 1'b1, 1'b0, 1'b0, "R6");
        wr(KB + 4, 16'h0000, 1'b1, 1'b0, 1'b0, "R6");
        wr(KB + 6, K3, 1'b1, 1'b0, 1'b0, "R6");
        acc(1'b0);
        chk_sec(2'b00, "R6 mismatch stays secured");

        // R7 out of order, then proper sequence in same session
        acc(1'b1);
        wr(KB + 2, K1, 1'b1, 1'b0, 1'b0, "R7");
        good_keys("R7");
        acc(1'b0);
        chk_sec(2'b00, "R7 out of order fails");

        // R7 outside window
        acc(1'b1);
        wr(16'h4000, K0, 1'b1, 1'b0, 1'b0, "R7 outside window not forwarded");
        good_keys("R7");
        acc(1'b0);
        chk_sec(2'b00, "R7 outside window fails");

        // R8 fifth write
        acc(1'b1);
        good_keys("R8");
        wr(KB, K0, 1'b1, 1'b0, 1'b0, "R8");
        acc(1'b0);
        chk_sec(2'b00, "R8 fifth write fails");

        // R9 byte write
        acc(1'b1);
        wr(KB, K0, 1'b0, 1'b0, 1'b0, "R9");
        good_keys("R9");
        acc(1'b0);
        chk_sec(2'b00, "R9 byte write fails");

        // R10 debug path in special mode
        special = 1'b1;
        acc(1'b1);
        wr(KB,     K0, 1'b1, 1'b1, 1'b0, "R10");
        wr(KB + 2, K1, 1'b1, 1'b1, 1'b0, "R10");
        wr(KB + 4, K2, 1'b1, 1'b1, 1'b0, "R10");
        wr(KB + 6, K3, 1'b1, 1'b1, 1'b0, "R10");
        acc(1'b0);
        chk_sec(2'b00, "R10 debug unlock blocked");

        // R14 write in the closing cycle is a command
        special = 1'b0;
        acc(1'b1);
        wr(KB,     K0, 1'b1, 1'b0, 1'b0, "R14");
        wr(KB + 2, K1, 1'b1, 1'b0, 1'b0, "R14");
        wr(KB + 4, K2, 1'b1, 1'b0, 1'b0, "R14");
        @(negedge clk);
        key_acc = 1'b0;
        wr_en = 1'b1; wr_addr = KB + 6; wr_data = K3;
        push("R14 closing write forwarded", K_CMD, 16'h0001);
        @(negedge clk);
        wr_en = 1'b0;
        chk_sec(2'b00, "R14 three words do not unlock");

        // R11 failed session followed by a clean one
        acc(1'b1);
        wr(KB + 4, K2, 1'b1, 1'b0, 1'b0, "R11");
        acc(1'b0);
        chk_sec(2'b00, "R11 failed session");
        acc(1'b1);
        good_keys("R11");
        acc(1'b0);
        chk_sec(2'b10, "R11 retry unlocks");

        // R10 normal write in special mode unlocks
        do_reset(2'b01, 1'b1);
        special = 1'b1;
        acc(1'b1);
        good_keys("R10");
        acc(1'b0);
        chk_sec(2'b10, "R10 normal path in special mode");
        special = 1'b0;

        // R13 key enable off
        do_reset(2'b01, 1'b0);
        chk_sec(2'b01, "R13 reset code 01");
        acc(1'b1);
        chk_rd(16'h7777, 16'h7777, "R13 read not masked");
        wr(KB,     K0, 1'b1, 1'b0, 1'b1, "R13 forwarded");
        wr(KB + 2, K1, 1'b1, 1'b0, 1'b1, "R13 forwarded");
        wr(KB + 4, K2, 1'b1, 1'b0, 1'b1, "R13 forwarded");
        wr(KB + 6, K3, 1'b1, 1'b0, 1'b1, "R13 forwarded");
        acc(1'b0);
        chk_sec(2'b01, "R13 no unlock");

        // R2 encodings
        do_reset(2'b11, 1'b1);
        chk_sec(2'b11, "R2 code 11 secured");
        do_reset(2'b10, 1'b1);
        chk_sec(2'b10, "R2 code 10 unsecured");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule